// File: doc/BRIEF.md
# Dual-Mode Position Counter with Capture

This block is a 32-bit up/down counter with two operating modes. In quadrature mode it decodes a pair of phase inputs from an incremental encoder and counts every valid edge, forwards or backwards, with an index input that zeroes the position. The phase and index inputs can be passed through a glitch filter. In timer mode the same counter advances on a tick enable and ignores the encoder inputs. If up/down operation is enabled, an external toggle event reverses the count direction.

In both modes the counter wraps between zero and a programmable top value. A compare register raises a one-cycle event and a sticky interrupt when the counter lands on it. A capture register takes a snapshot of the counter on an external event. It refuses a new snapshot until the old one has been read, and flags an overrun instead. Software sees the block through a small register write/read port. The encoder, tick, toggle and capture inputs are synchronous to `clk`.

Top module: `quad_timer`

## Requirements
- R1: After reset the counter, CTRL, CMP and STATUS read 0, TOP reads all ones, and `cmp_evt` and `irq` are low. The register addresses are CTRL=0, TOP=1, CMP=2, CNT=3 (read only), CAP=4 (read only) and STATUS=5. CTRL holds run in bit 0, quadrature mode in bit 1, filter enable in bit 2 and up/down enable in bit 3. STATUS holds overrun in bit 0, capture-unread in bit 1 and the compare flag in bit 2.
- R2: In quadrature mode with run set, each transition of {A,B} through the sequence 00→10→11→01→00 (A leading B) adds one, and each transition in the reverse order subtracts one. A transition that changes both phases at once does not count. Without filtering, the count appears after the first rising clock edge that sees the new levels.
- R3: In quadrature mode with run set, a rising edge on the index input clears the counter. In timer mode the index input has no effect.
- R4: With the filter enabled, a change on A, B or index takes effect only after the raw level has held for three consecutive clock cycles, so a count appears on the fourth rising edge. A change that lasts fewer cycles is ignored. In timer mode the phase inputs have no effect.
- R5: In timer mode with run set, each cycle with `tick` high changes the counter by one.
- R6: Counting up from TOP gives 0, and counting down from 0 gives TOP.
- R7: In timer mode with up/down enable set, each `dir_tgl` pulse reverses the count direction. The direction is up after reset and whenever up/down enable is clear.
- R8: When a count step leaves the counter equal to CMP, `cmp_evt` is high for that one cycle and the compare flag (`irq`) sets. Writing 1 to STATUS bit 2 clears the flag.
- R9: A `cap_evt` pulse copies the current counter into CAP and sets capture-unread, but only while run is set.
- R10: A `cap_evt` while capture-unread is set leaves CAP unchanged and sets overrun. Reading CAP clears capture-unread. Writing 1 to STATUS bit 0 clears overrun.
- R11: With run clear, the counter holds its value whatever the tick, phase or index inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the filter sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (acts on CAP only) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| ph_a | input | 1 | Encoder phase A |
| ph_b | input | 1 | Encoder phase B |
| ph_idx | input | 1 | Encoder index |
| tick | input | 1 | Timer-mode count enable |
| dir_tgl | input | 1 | Direction toggle event |
| cap_evt | input | 1 | Capture event |
| cmp_evt | output | 1 | One-cycle compare event |
| irq | output | 1 | Sticky compare interrupt |

## Verification
On every cycle the assertions check the wrap at TOP and at zero, counter hold while stopped, index clearing, the filter's three-cycle hold before its output moves, the compare event against CMP, and that CAP is frozen while unread, with overrun raised on a refused capture. The bench scenarios alone show the direction decoding of the phase sequence across a walk that includes illegal double transitions. They also show the exact latency with and without filtering, the rejection of short glitches, the toggle-driven direction reversal, and the read-to-clear and write-one-to-clear behaviour of the status bits.

// File: rtl/qt_pkg.sv
package qt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_TOP  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

  typedef struct packed {
    logic updn;
    logic filt;
    logic quad;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/qt_glitch_filter.sv
module qt_glitch_filter #(
  parameter int STABLE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic flt
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] hold_q, hold_d;
  logic          flt_q, flt_d;

  always_comb begin
    hold_d = '0;
    flt_d  = flt_q;
    if (raw != flt_q) begin
      if (hold_q == LAST) begin
        flt_d = raw;
      end else begin
        hold_d = hold_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      flt_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      flt_q  <= flt_d;
    end
  end

  assign flt = flt_q;

  generate
    if (STABLE_CYCLES >= 3) begin : g_chk
      AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flt_q) |-> ($past(raw) == flt_q) && ($past(raw, 2) == flt_q)
                            && ($past(raw, 3) == flt_q)); // R4
    end
  endgenerate
endmodule

// File: rtl/qt_quad_decode.sv
module qt_quad_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  input  logic idx,
  output logic step,
  output logic up,
  output logic idx_rise
);
  logic a_q, b_q, i_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      i_q <= 1'b0;
    end else begin
      a_q <= a;
      b_q <= b;
      i_q <= idx;
    end
  end

  // exactly one phase moved: a legal Gray step
  assign step     = (a ^ a_q) ^ (b ^ b_q);
  // forward order 00->10->11->01: old A equals new B
  assign up       = (a_q == b);
  assign idx_rise = idx & ~i_q;
endmodule

// File: rtl/qt_count_core.sv
module qt_count_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         step,
  input  logic         up,
  input  logic         clr,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (clr) begin
        cnt_d = '0;
      end else if (step) begin
        if (up) begin
          cnt_d = (cnt_q >= top) ? '0 : cnt_q + ONE;
        end else begin
          cnt_d = (cnt_q == '0) ? top : cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign cnt_nxt = cnt_d;

  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr && step && up && (cnt_q == top) |=> cnt_q == '0); // R6
  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr && step && !up && (cnt_q == '0) |=> cnt_q == $past(top)); // R6
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q)); // R11
  AST_INDEX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    en && clr |=> cnt_q == '0); // R3
endmodule

// File: rtl/quad_timer.sv
module quad_timer
  import qt_pkg::*;
#(
  parameter int W         = 32,
  parameter int FILT_HOLD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic              ph_a,
  input  logic              ph_b,
  input  logic              ph_idx,
  input  logic              tick,
  input  logic              dir_tgl,
  input  logic              cap_evt,
  output logic              cmp_evt,
  output logic              irq
);
  localparam int NIN = 3;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q, rn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rn = rst_sync_q;

  // registers
  ctrl_t        ctrl_q, ctrl_d;
  logic [W-1:0] top_q, top_d, cmp_q, cmp_d, cap_q, cap_d;
  logic         full_q, full_d, ovr_q, ovr_d, cmpf_q, cmpf_d;
  logic         dir_q, dir_d, evt_q, evt_d;

  // input conditioning
  logic [NIN-1:0] raw_in, flt_in, sel_in;
  assign raw_in = {ph_idx, ph_b, ph_a};

  generate
    for (genvar gi = 0; gi < NIN; gi++) begin : g_filt
      qt_glitch_filter #(.STABLE_CYCLES(FILT_HOLD)) u_filt (
        .clk (clk),
        .rst_n(rn),
        .raw (raw_in[gi]),
        .flt (flt_in[gi])
      );
    end
  endgenerate

  assign sel_in = ctrl_q.filt ? flt_in : raw_in;

  logic q_step, q_up, q_idx;
  qt_quad_decode u_dec (
    .clk     (clk),
    .rst_n   (rn),
    .a       (sel_in[0]),
    .b       (sel_in[1]),
    .idx     (sel_in[2]),
    .step    (q_step),
    .up      (q_up),
    .idx_rise(q_idx)
  );

  // mode selection
  logic step_sel, up_sel, clr_sel;
  assign step_sel = ctrl_q.quad ? q_step : tick;
  assign up_sel   = ctrl_q.quad ? q_up   : dir_q;
  assign clr_sel  = ctrl_q.quad & q_idx;

  logic [W-1:0] cnt, cnt_nxt;
  qt_count_core #(.W(W)) u_core (
    .clk    (clk),
    .rst_n  (rn),
    .en     (ctrl_q.run),
    .step   (step_sel),
    .up     (up_sel),
    .clr    (clr_sel),
    .top    (top_q),
    .cnt    (cnt),
    .cnt_nxt(cnt_nxt)
  );

  // next-state logic
  logic wr_ctrl, wr_top, wr_cmp, wr_stat, rd_cap, cap_ok, hit;
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_top  = wr_en && (wr_addr == A_TOP);
  assign wr_cmp  = wr_en && (wr_addr == A_CMP);
  assign wr_stat = wr_en && (wr_addr == A_STAT);
  assign rd_cap  = rd_en && (rd_addr == A_CAP);
  assign cap_ok  = cap_evt && ctrl_q.run;
  assign hit     = ctrl_q.run && (step_sel || clr_sel) && (cnt_nxt == cmp_q);

  always_comb begin
    ctrl_d = ctrl_q;
    top_d  = top_q;
    cmp_d  = cmp_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(wr_data[3:0]);
    if (wr_top)  top_d  = wr_data;
    if (wr_cmp)  cmp_d  = wr_data;

    dir_d = dir_q;
    if (!ctrl_q.updn || ctrl_q.quad) dir_d = 1'b1;
    else if (dir_tgl)                dir_d = ~dir_q;

    cap_d  = cap_q;
    full_d = full_q;
    ovr_d  = ovr_q;
    if (wr_stat && wr_data[0]) ovr_d = 1'b0;
    if (cap_ok && (!full_q || rd_cap)) begin
      cap_d  = cnt;
      full_d = 1'b1;
    end else begin
      if (rd_cap) full_d = 1'b0;
      if (cap_ok) ovr_d  = 1'b1;
    end

    cmpf_d = cmpf_q;
    if (wr_stat && wr_data[2]) cmpf_d = 1'b0;
    if (hit)                   cmpf_d = 1'b1;
    evt_d = hit;
  end

  always_ff @(posedge clk or negedge rn) begin
    if (!rn) begin
      ctrl_q <= '0;
      top_q  <= '1;
      cmp_q  <= '0;
      cap_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      cmpf_q <= 1'b0;
      dir_q  <= 1'b1;
      evt_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      top_q  <= top_d;
      cmp_q  <= cmp_d;
      cap_q  <= cap_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
      cmpf_q <= cmpf_d;
      dir_q  <= dir_d;
      evt_q  <= evt_d;
    end
  end

  // read port
  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL:  rd_data = {{(W-4){1'b0}}, ctrl_q};
      A_TOP:   rd_data = top_q;
      A_CMP:   rd_data = cmp_q;
      A_CNT:   rd_data = cnt;
      A_CAP:   rd_data = cap_q;
      A_STAT:  rd_data = {{(W-3){1'b0}}, cmpf_q, full_q, ovr_q};
      default: rd_data = '0;
    endcase
  end

  assign cmp_evt = evt_q;
  assign irq     = cmpf_q;

  AST_CMP_MATCH: assert property (@(posedge clk) disable iff (!rn)
    cmp_evt |-> cnt == $past(cmp_q)); // R8
  AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rn)
    cmp_evt |-> irq); // R8
  AST_CAP_FROZEN: assert property (@(posedge clk) disable iff (!rn)
    full_q && !rd_cap |=> $stable(cap_q)); // R10
  AST_OVR_RAISE: assert property (@(posedge clk) disable iff (!rn)
    cap_evt && ctrl_q.run && full_q && !rd_cap |=> ovr_q); // R10
  AST_CAP_STOPPED: assert property (@(posedge clk) disable iff (!rn)
    !ctrl_q.run && !rd_cap |=> $stable(cap_q) && $stable(full_q)); // R9
endmodule

// File: tb/quad_timer_test.sv
module quad_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        ph_a, ph_b, ph_idx, tick, dir_tgl, cap_evt;
  logic        cmp_evt, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  quad_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ph_a(ph_a), .ph_b(ph_b), .ph_idx(ph_idx), .tick(tick),
    .dir_tgl(dir_tgl), .cap_evt(cap_evt), .cmp_evt(cmp_evt), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] c, input bit up, input logic [31:0] t);
    if (up) return (c >= t) ? 32'd0 : c + 32'd1;
    return (c == 32'd0) ? t : c - 32'd1;
  endfunction

  // Gray position 0..3 -> {A,B}: 00,10,11,01
  task automatic set_pos(input int p);
    case (p & 3)
      0: begin ph_a = 1'b0; ph_b = 1'b0; end
      1: begin ph_a = 1'b1; ph_b = 1'b0; end
      2: begin ph_a = 1'b1; ph_b = 1'b1; end
      default: begin ph_a = 1'b0; ph_b = 1'b1; end
    endcase
  endtask

  logic [31:0] v, m, top;
  int          pos;
  int unsigned lcg;

  task automatic do_tick(input string req, input bit up);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    m = nxt(m, up, top);
    chk({req, " R8 cmp_evt"}, {31'd0, cmp_evt}, {31'd0, m == 32'd3});
    rd(3'd3, v);
    chk(req, v, m);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    ph_a = 0; ph_b = 0; ph_idx = 0; tick = 0; dir_tgl = 0; cap_evt = 0;
    lcg = 32'h1234_5678;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    rd(3'd3, v); chk("R1 CNT", v, 0);
    rd(3'd0, v); chk("R1 CTRL", v, 0);
    rd(3'd1, v); chk("R1 TOP", v, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R1 CMP", v, 0);
    rd(3'd5, v); chk("R1 STATUS", v, 0);
    chk("R1 outputs", {30'd0, cmp_evt, irq}, 0);

    // R5 R6 timer up sweep, TOP=5, CMP=3
    top = 32'd5; m = 0;
    wr(3'd1, top); wr(3'd2, 32'd3); wr(3'd0, 32'h1);
    for (int i = 0; i < 20; i++) do_tick("R5 R6 timer up", 1'b1);
    chk("R8 irq sticky", {31'd0, irq}, 1);
    rd(3'd5, v); chk("R8 status flag", v & 32'h4, 32'h4);
    wr(3'd5, 32'h4);
    chk("R8 irq cleared", {31'd0, irq}, 0);

    // R11 stopped counter ignores tick
    wr(3'd0, 32'h0);
    for (int i = 0; i < 3; i++) begin tick = 1; @(negedge clk); tick = 0; end
    rd(3'd3, v); chk("R11 hold", v, m);

    // R7 up/down toggle
    wr(3'd0, 32'h9);
    dir_tgl = 1; @(negedge clk); dir_tgl = 0;
    for (int i = 0; i < 10; i++) do_tick("R7 R6 timer down", 1'b0);
    dir_tgl = 1; @(negedge clk); dir_tgl = 0;
    for (int i = 0; i < 3; i++) do_tick("R7 timer up again", 1'b1);

    // quadrature mode, no filter
    top = 32'd9;
    wr(3'd1, top); wr(3'd0, 32'h3);
    ph_idx = 1; @(negedge clk); ph_idx = 0;
    m = 0;
    rd(3'd3, v); chk("R3 index clear", v, m);
    pos = 0;
    for (int i = 0; i < 48; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      case (lcg[17:16])
        2'd0, 2'd1: begin pos = pos + 1; m = nxt(m, 1'b1, top); end
        2'd2:       begin pos = pos + 3; m = nxt(m, 1'b0, top); end
        default:    begin pos = pos + 2; end
      endcase
      set_pos(pos);
      @(negedge clk);
      rd(3'd3, v); chk("R2 R6 quad walk", v, m);
    end

    // R3 R4 timer mode ignores phases and index
    wr(3'd0, 32'h1);
    set_pos(pos + 1); ph_idx = 1; cyc(2);
    set_pos(pos);     ph_idx = 0; cyc(2);
    rd(3'd3, v); chk("R3 R4 timer ignores encoder", v, m);

    // R4 filtered quadrature
    wr(3'd0, 32'h7);
    cyc(4);
    set_pos(pos + 1); cyc(2); set_pos(pos); cyc(5);
    rd(3'd3, v); chk("R4 short glitch ignored", v, m);
    pos = pos + 1; set_pos(pos); cyc(3);
    rd(3'd3, v); chk("R4 not yet after three", v, m);
    m = nxt(m, 1'b1, top);
    rd(3'd3, v); chk("R4 counted on fourth edge", v, m);
    pos = pos + 1; set_pos(pos); cyc(5);
    m = nxt(m, 1'b1, top);
    rd(3'd3, v); chk("R4 second filtered step", v, m);
    ph_idx = 1; cyc(2); ph_idx = 0; cyc(5);
    rd(3'd3, v); chk("R4 short index ignored", v, m);
    ph_idx = 1; cyc(3); ph_idx = 0; cyc(3);
    m = 0;
    rd(3'd3, v); chk("R3 R4 filtered index clear", v, m);

    // R9 R10 capture
    wr(3'd0, 32'h0);
    cap_evt = 1; @(negedge clk); cap_evt = 0;
    rd(3'd5, v); chk("R9 no capture while stopped", v & 32'h3, 0);
    wr(3'd0, 32'h1);
    top = 32'd9;
    for (int i = 0; i < 2; i++) begin tick = 1; @(negedge clk); tick = 0; m = nxt(m, 1'b1, top); end
    cap_evt = 1; @(negedge clk); cap_evt = 0;
    rd(3'd5, v); chk("R9 unread set", v & 32'h3, 32'h2);
    tick = 1; @(negedge clk); tick = 0;
    cap_evt = 1; @(negedge clk); cap_evt = 0;
    rd(3'd5, v); chk("R10 overrun set", v & 32'h3, 32'h3);
    rd(3'd4, v); chk("R9 R10 CAP keeps first value", v, m);
    m = nxt(m, 1'b1, top);
    rd(3'd5, v); chk("R10 read clears unread", v & 32'h3, 32'h1);
    wr(3'd5, 32'h1);
    rd(3'd5, v); chk("R10 overrun cleared", v & 32'h3, 32'h0);
    cap_evt = 1; @(negedge clk); cap_evt = 0;
    rd(3'd4, v); chk("R9 new capture after read", v, m);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule